// File: doc/BRIEF.md
# Rename Stage with Move and Constant-Add Folding

This block renames a group of up to `W` decoded instructions per cycle. It maps each architectural register to a physical register. Each map entry also carries a signed offset that a consumer adds to the register's value before use. Two kinds of instruction become map-table updates and never reach an execution unit: register copies, and adds of a small immediate. The destination entry takes the source's physical register. For a copy it also takes the source offset. For an add it takes the source offset plus the immediate. The stage marks such a slot as eliminated.

Each slot that writes a register and is not eliminated takes a fresh physical register from a free-list FIFO. The whole group waits when the free list is short. An eliminated slot adds one reference to a per-register share counter. A release arriving at commit decrements that counter. When the counter is already zero, the release returns the register to the free list instead. A flush puts the map back to identity with zero offsets, refills the free list and clears all share counters, all in one cycle.

Top module: `rn_stage`

## Requirements
- R1: A slot of class 1 (copy, `rd = rs1`) that writes a register is eliminated. Its destination maps to the physical register and offset of `rs1`, and it takes no free-list entry.
- R2: A slot of class 3 (`rd = rs1 OR rs2`) is eliminated like a copy when `rs1 == rs2`. When the two fields differ it is renamed normally.
- R3: A slot of class 2 (`rd = rs1 + imm`, imm a 12-bit two's complement field) can be folded only when imm lies in -1024..1023. Otherwise it is renamed normally.
- R4: A class 2 slot folds only if the source offset plus imm lies in -4096..4095, with both limits included. When it folds, the destination offset becomes that sum. Otherwise the slot is renamed normally with offset 0.
- R5: All `W` slots of one group (default 6) can be eliminated in the same cycle.
- R6: A slot reads the mapping and offset left by every earlier slot of the same group, in slot order.
- R7: Each valid, writing, non-eliminated slot receives the next free-list entry, in slot order. When the free list holds fewer entries than the group needs, `grp_ready` is 0. The group then produces no output and changes no state. `out_vld` rises one cycle after an accepted group.
- R8: For each valid slot `i`, the outputs carry the physical register and 13-bit offset of both sources, plus a flag that is 1 exactly when that offset is nonzero. All of these sit in bit slice `i` of each output bus. `out_pd` gives the allocated or aliased register, or 0 when the slot writes nothing. An invalid slot outputs all zeros.
- R9: `flush` restores register `a` to physical `a` with offset 0. It refills the free list with `NARCH..NPHYS-1` in ascending order and clears the share counters. A group or release presented in the same cycle is ignored.
- R10: Each eliminated slot increments the share count of its aliased register. A release of a register with a nonzero count decrements the count. A release of a register whose count is zero appends that register to the free list.
- R11: After reset, the map is identity, the free list holds `NARCH..NPHYS-1` in ascending order, `out_vld` is 0 and `grp_ready` is 1 for an empty group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Restore identity map, free list and share counts |
| grp_valid | input | 1 | Group present on the slot inputs |
| grp_ready | output | 1 | Group can be accepted this cycle |
| slot_vld | input | W | Per-slot valid |
| slot_wr | input | W | Per-slot writes a destination |
| slot_cls | input | 2*W | Per-slot class: 0 other, 1 copy, 2 add-immediate, 3 OR |
| slot_rd | input | W*AW | Destination architectural register |
| slot_rs1 | input | W*AW | First source architectural register |
| slot_rs2 | input | W*AW | Second source architectural register |
| slot_imm | input | W*IMM_W | Signed immediate |
| rel_valid | input | 1 | Commit release of one physical register |
| rel_preg | input | PW | Register being released |
| out_vld | output | 1 | Renamed group valid |
| out_elim | output | W | Slot was eliminated |
| out_pd | output | W*PW | Destination physical register |
| out_ps1 | output | W*PW | First source physical register |
| out_ps2 | output | W*PW | Second source physical register |
| out_off1 | output | W*OFF_W | First source offset |
| out_off2 | output | W*OFF_W | Second source offset |
| out_nz1 | output | W | First source offset nonzero |
| out_nz2 | output | W | Second source offset nonzero |

## Verification
The assertions rely on three properties of the inputs. Releases never push more registers than the free-list depth. No physical register collects more shares than its counter can hold. `NPHYS` is a power of two, so the FIFO pointers wrap on their own. The stimulus keeps to these limits in three ways. It releases only a register whose shares it has just created. It flushes every five groups in the random phase. It uses at most thirty eliminations between flushes.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    CLS_ALU  = 2'd0,
    CLS_MOV  = 2'd1,
    CLS_ADDI = 2'd2,
    CLS_OR   = 2'd3
  } rn_cls_e;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int W     = 6,
  parameter int NARCH = 32,
  parameter int NPHYS = 64,
  localparam int PW    = $clog2(NPHYS),
  localparam int CW    = $clog2(W + 1),
  localparam int NFREE = NPHYS - NARCH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [CW-1:0]          pop_n,
  input  logic                   push,
  input  logic [PW-1:0]          push_preg,
  output logic [PW:0]            avail,
  output logic [W-1:0][PW-1:0]   peek
);

  logic [NPHYS-1:0][PW-1:0] mem_q, mem_d;
  logic [PW-1:0]            head_q, head_d, tail_q, tail_d;
  logic [PW:0]              cnt_q, cnt_d;

  function automatic logic [NPHYS-1:0][PW-1:0] init_mem();
    logic [NPHYS-1:0][PW-1:0] m;
    for (int i = 0; i < NPHYS; i++) m[i] = (i < NFREE) ? PW'(NARCH + i) : '0;
    return m;
  endfunction

  assign avail = cnt_q;

  always_comb begin
    for (int i = 0; i < W; i++) peek[i] = mem_q[head_q + PW'(i)];
  end

  always_comb begin
    mem_d  = mem_q;
    head_d = head_q + PW'(pop_n);
    tail_d = tail_q;
    cnt_d  = cnt_q - (PW+1)'(pop_n) + (PW+1)'(push);
    if (push) begin
      mem_d[tail_q] = push_preg;
      tail_d        = tail_q + PW'(1);
    end
    if (flush) begin
      mem_d  = init_mem();
      head_d = '0;
      tail_d = PW'(NFREE);
      cnt_d  = (PW+1)'(NFREE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q  <= init_mem();
      head_q <= '0;
      tail_q <= PW'(NFREE);
      cnt_q  <= (PW+1)'(NFREE);
    end else begin
      mem_q  <= mem_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  p_pop_within_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> ((PW+1)'(pop_n) <= cnt_q));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> (cnt_q < (PW+1)'(NPHYS)));

endmodule

// File: rtl/rn_sharecnt.sv
module rn_sharecnt #(
  parameter int W     = 6,
  parameter int NPHYS = 64,
  parameter int SHR_W = 6,
  localparam int PW = $clog2(NPHYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic [W-1:0]         inc_en,
  input  logic [W-1:0][PW-1:0] inc_preg,
  input  logic                 rel_valid,
  input  logic [PW-1:0]        rel_preg,
  output logic                 rel_free
);

  logic [NPHYS-1:0][SHR_W-1:0] cnt_q, cnt_d, add_n;

  assign rel_free = rel_valid && (cnt_q[rel_preg] == '0);

  always_comb begin
    for (int p = 0; p < NPHYS; p++) begin
      add_n[p] = '0;
      for (int i = 0; i < W; i++)
        if (inc_en[i] && (inc_preg[i] == PW'(p))) add_n[p] = add_n[p] + SHR_W'(1);
      cnt_d[p] = cnt_q[p] + add_n[p];
      if (rel_valid && (rel_preg == PW'(p)) && (cnt_q[p] != '0))
        cnt_d[p] = cnt_d[p] - SHR_W'(1);
    end
    if (flush) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NPHYS; g++) begin : g_chk
    p_share_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (SHR_W'(cnt_q[g] + add_n[g]) >= cnt_q[g]));
  end

endmodule

// File: rtl/rn_maptable.sv
module rn_maptable
  import rn_pkg::*;
#(
  parameter int W       = 6,
  parameter int NARCH   = 32,
  parameter int NPHYS   = 64,
  parameter int IMM_W   = 12,
  parameter int OFF_W   = 13,
  parameter int IMM_LIM = 1024,
  localparam int AW      = $clog2(NARCH),
  localparam int PW      = $clog2(NPHYS),
  localparam int CW      = $clog2(W + 1),
  localparam int OFF_LIM = 2 ** (OFF_W - 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    fire,
  input  logic [W-1:0]            slot_vld,
  input  logic [W-1:0]            slot_wr,
  input  logic [2*W-1:0]          slot_cls,
  input  logic [W*AW-1:0]         slot_rd,
  input  logic [W*AW-1:0]         slot_rs1,
  input  logic [W*AW-1:0]         slot_rs2,
  input  logic [W*IMM_W-1:0]      slot_imm,
  input  logic [W-1:0][PW-1:0]    peek,
  output logic [W-1:0]            elim,
  output logic [W-1:0][PW-1:0]    pd,
  output logic [W-1:0][PW-1:0]    ps1,
  output logic [W-1:0][PW-1:0]    ps2,
  output logic [W-1:0][OFF_W-1:0] off1,
  output logic [W-1:0][OFF_W-1:0] off2,
  output logic [W-1:0]            nz1,
  output logic [W-1:0]            nz2,
  output logic [CW-1:0]           n_alloc
);

  logic [NARCH-1:0][PW-1:0]    map_p, map_p_d, cur_p;
  logic [NARCH-1:0][OFF_W-1:0] map_o, map_o_d, cur_o;

  function automatic logic [NARCH-1:0][PW-1:0] ident_map();
    logic [NARCH-1:0][PW-1:0] m;
    for (int a = 0; a < NARCH; a++) m[a] = PW'(a);
    return m;
  endfunction

  // Walk the group in slot order over a running copy of the map.
  always_comb begin
    logic [AW-1:0]    a1, a2, ad;
    rn_cls_e          cls;
    int               imm_i, sum_i;
    logic [PW-1:0]    src_p;
    logic [OFF_W-1:0] src_o;
    logic             can;
    logic [CW-1:0]    k;
    cur_p = map_p;
    cur_o = map_o;
    k     = '0;
    elim  = '0;
    pd    = '0;
    ps1   = '0;
    ps2   = '0;
    off1  = '0;
    off2  = '0;
    for (int i = 0; i < W; i++) begin
      a1    = slot_rs1[i*AW +: AW];
      a2    = slot_rs2[i*AW +: AW];
      ad    = slot_rd[i*AW +: AW];
      cls   = rn_cls_e'(slot_cls[2*i +: 2]);
      imm_i = int'($signed(slot_imm[i*IMM_W +: IMM_W]));
      src_p = cur_p[a1];
      src_o = cur_o[a1];
      sum_i = int'($signed(src_o)) + imm_i;
      case (cls)
        CLS_MOV:  can = 1'b1;
        CLS_OR:   can = (a1 == a2);
        CLS_ADDI: can = (imm_i >= -IMM_LIM) && (imm_i < IMM_LIM) &&
                        (sum_i >= -OFF_LIM) && (sum_i < OFF_LIM);
        default:  can = 1'b0;
      endcase
      if (slot_vld[i]) begin
        ps1[i]  = src_p;
        off1[i] = src_o;
        ps2[i]  = cur_p[a2];
        off2[i] = cur_o[a2];
        if (slot_wr[i]) begin
          if (can) begin
            elim[i]   = 1'b1;
            pd[i]     = src_p;
            cur_p[ad] = src_p;
            cur_o[ad] = (cls == CLS_ADDI) ? sum_i[OFF_W-1:0] : src_o;
          end else begin
            pd[i]     = peek[k];
            cur_p[ad] = peek[k];
            cur_o[ad] = '0;
            k         = k + CW'(1);
          end
        end
      end
    end
    n_alloc = k;
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      nz1[i] = |off1[i];
      nz2[i] = |off2[i];
    end
  end

  always_comb begin
    map_p_d = map_p;
    map_o_d = map_o;
    if (flush) begin
      map_p_d = ident_map();
      map_o_d = '0;
    end else if (fire) begin
      map_p_d = cur_p;
      map_o_d = cur_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_p <= ident_map();
      map_o <= '0;
    end else begin
      map_p <= map_p_d;
      map_o <= map_o_d;
    end
  end

  p_flush_identity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (map_p == ident_map()) && (map_o == '0));

  p_stall_holds_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !flush) |=> ($stable(map_p) && $stable(map_o)));

endmodule

// File: rtl/rn_stage.sv
module rn_stage #(
  parameter int W       = 6,
  parameter int NARCH   = 32,
  parameter int NPHYS   = 64,
  parameter int IMM_W   = 12,
  parameter int OFF_W   = 13,
  parameter int IMM_LIM = 1024,
  parameter int SHR_W   = 6,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS),
  localparam int CW = $clog2(W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 grp_valid,
  output logic                 grp_ready,
  input  logic [W-1:0]         slot_vld,
  input  logic [W-1:0]         slot_wr,
  input  logic [2*W-1:0]       slot_cls,
  input  logic [W*AW-1:0]      slot_rd,
  input  logic [W*AW-1:0]      slot_rs1,
  input  logic [W*AW-1:0]      slot_rs2,
  input  logic [W*IMM_W-1:0]   slot_imm,
  input  logic                 rel_valid,
  input  logic [PW-1:0]        rel_preg,
  output logic                 out_vld,
  output logic [W-1:0]         out_elim,
  output logic [W*PW-1:0]      out_pd,
  output logic [W*PW-1:0]      out_ps1,
  output logic [W*PW-1:0]      out_ps2,
  output logic [W*OFF_W-1:0]   out_off1,
  output logic [W*OFF_W-1:0]   out_off2,
  output logic [W-1:0]         out_nz1,
  output logic [W-1:0]         out_nz2
);

  logic [W-1:0][PW-1:0]    peek, pd, ps1, ps2;
  logic [W-1:0][OFF_W-1:0] off1, off2;
  logic [W-1:0]            elim, nz1, nz2;
  logic [CW-1:0]           n_alloc, pop_n;
  logic [PW:0]             avail;
  logic                    fire, rel_free;

  assign grp_ready = !flush && ((PW+1)'(n_alloc) <= avail);
  assign fire      = grp_valid && grp_ready;
  assign pop_n     = fire ? n_alloc : '0;

  rn_maptable #(.W(W), .NARCH(NARCH), .NPHYS(NPHYS), .IMM_W(IMM_W),
                .OFF_W(OFF_W), .IMM_LIM(IMM_LIM)) u_map (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fire(fire),
    .slot_vld(slot_vld), .slot_wr(slot_wr), .slot_cls(slot_cls),
    .slot_rd(slot_rd), .slot_rs1(slot_rs1), .slot_rs2(slot_rs2),
    .slot_imm(slot_imm), .peek(peek), .elim(elim), .pd(pd),
    .ps1(ps1), .ps2(ps2), .off1(off1), .off2(off2),
    .nz1(nz1), .nz2(nz2), .n_alloc(n_alloc));

  rn_freelist #(.W(W), .NARCH(NARCH), .NPHYS(NPHYS)) u_fl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pop_n(pop_n),
    .push(rel_free), .push_preg(rel_preg), .avail(avail), .peek(peek));

  rn_sharecnt #(.W(W), .NPHYS(NPHYS), .SHR_W(SHR_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .inc_en(fire ? elim : '0), .inc_preg(pd),
    .rel_valid(rel_valid), .rel_preg(rel_preg), .rel_free(rel_free));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_elim <= '0;
      out_pd   <= '0;
      out_ps1  <= '0;
      out_ps2  <= '0;
      out_off1 <= '0;
      out_off2 <= '0;
      out_nz1  <= '0;
      out_nz2  <= '0;
    end else begin
      out_vld <= fire;
      if (fire) begin
        out_elim <= elim;
        out_pd   <= pd;
        out_ps1  <= ps1;
        out_ps2  <= ps2;
        out_off1 <= off1;
        out_off2 <= off2;
        out_nz1  <= nz1;
        out_nz2  <= nz2;
      end
    end
  end

  p_stall_no_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !grp_ready) |=> !out_vld);

endmodule

// File: tb/tb_rn_stage.sv
`timescale 1ns/1ps
module tb_rn_stage;
  localparam int W = 6, AW = 5, PW = 6, OW = 13, IW = 12;
  localparam int NARCH = 32, NPHYS = 64;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, grp_valid = 1'b0;
  logic grp_ready, rel_valid = 1'b0, out_vld;
  logic [PW-1:0] rel_preg = '0;
  logic [W-1:0] slot_vld = '0, slot_wr = '0;
  logic [2*W-1:0] slot_cls = '0;
  logic [W*AW-1:0] slot_rd = '0, slot_rs1 = '0, slot_rs2 = '0;
  logic [W*IW-1:0] slot_imm = '0;
  logic [W-1:0] out_elim, out_nz1, out_nz2;
  logic [W*PW-1:0] out_pd, out_ps1, out_ps2;
  logic [W*OW-1:0] out_off1, out_off2;

  always #2 clk = ~clk;

  rn_stage dut (.*);

  typedef struct {
    logic [W-1:0] elim, n1, n2;
    logic [W*PW-1:0] pd, ps1, ps2;
    logic [W*OW-1:0] o1, o2;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  int m_p[NARCH], m_o[NARCH], m_sh[NPHYS];
  int fl[$];
  int s_vld[W], s_wr[W], s_cls[W], s_rd[W], s_rs1[W], s_rs2[W], s_imm[W];

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s", msg); end
  endtask

  task automatic model_reset();
    for (int a = 0; a < NARCH; a++) begin m_p[a] = a; m_o[a] = 0; end
    for (int p = 0; p < NPHYS; p++) m_sh[p] = 0;
    fl = {};
    for (int p = NARCH; p < NPHYS; p++) fl.push_back(p);
  endtask

  task automatic clr();
    for (int i = 0; i < W; i++) begin
      s_vld[i] = 0; s_wr[i] = 0; s_cls[i] = 0; s_rd[i] = 0;
      s_rs1[i] = 0; s_rs2[i] = 0; s_imm[i] = 0;
    end
  endtask

  task automatic slot(input int i, input int cls, input int rd, input int rs1,
                      input int rs2, input int imm);
    s_vld[i] = 1; s_wr[i] = 1; s_cls[i] = cls; s_rd[i] = rd;
    s_rs1[i] = rs1; s_rs2[i] = rs2; s_imm[i] = imm;
  endtask

  // Driver: predicts the group from the requirements and queues the result.
  task automatic send(input string tag);
    exp_t e;
    int tp[NARCH], to[NARCH];
    int nal, p1, o1, p2, o2, sum, np;
    int inc[$];
    bit can, exp_rdy;
    @(negedge clk);
    for (int i = 0; i < W; i++) begin
      slot_vld[i] = s_vld[i][0];
      slot_wr[i] = s_wr[i][0];
      slot_cls[2*i +: 2] = s_cls[i][1:0];
      slot_rd[i*AW +: AW] = s_rd[i][AW-1:0];
      slot_rs1[i*AW +: AW] = s_rs1[i][AW-1:0];
      slot_rs2[i*AW +: AW] = s_rs2[i][AW-1:0];
      slot_imm[i*IW +: IW] = s_imm[i][IW-1:0];
    end
    grp_valid = 1'b1;
    tp = m_p; to = m_o; nal = 0;
    e.elim = '0; e.n1 = '0; e.n2 = '0; e.pd = '0;
    e.ps1 = '0; e.ps2 = '0; e.o1 = '0; e.o2 = '0;
    for (int i = 0; i < W; i++) begin
      if (s_vld[i] != 0) begin
        p1 = tp[s_rs1[i]]; o1 = to[s_rs1[i]];
        p2 = tp[s_rs2[i]]; o2 = to[s_rs2[i]];
        e.ps1[i*PW +: PW] = p1[PW-1:0]; e.o1[i*OW +: OW] = o1[OW-1:0]; e.n1[i] = (o1 != 0);
        e.ps2[i*PW +: PW] = p2[PW-1:0]; e.o2[i*OW +: OW] = o2[OW-1:0]; e.n2[i] = (o2 != 0);
        if (s_wr[i] != 0) begin
          sum = o1 + s_imm[i];
          can = (s_cls[i] == 1) || (s_cls[i] == 3 && s_rs1[i] == s_rs2[i]) ||
                (s_cls[i] == 2 && s_imm[i] >= -1024 && s_imm[i] <= 1023 &&
                 sum >= -4096 && sum <= 4095);
          if (can) begin
            e.elim[i] = 1'b1; e.pd[i*PW +: PW] = p1[PW-1:0];
            tp[s_rd[i]] = p1; to[s_rd[i]] = (s_cls[i] == 2) ? sum : o1;
            inc.push_back(p1);
          end else begin
            np = (nal < fl.size()) ? fl[nal] : 0;
            e.pd[i*PW +: PW] = np[PW-1:0];
            tp[s_rd[i]] = np; to[s_rd[i]] = 0;
            nal++;
          end
        end
      end
    end
    #1;
    exp_rdy = (nal <= fl.size());
    n_chk++;
    if (grp_ready !== exp_rdy) begin
      n_fail++;
      $display("FAIL R7 %s grp_ready got %b exp %b", tag, grp_ready, exp_rdy);
    end
    if (exp_rdy) begin
      m_p = tp; m_o = to;
      repeat (nal) void'(fl.pop_front());
      foreach (inc[j]) m_sh[inc[j]]++;
      e.tag = tag;
      q.push_back(e);
      @(posedge clk);
      #1;
    end
    grp_valid = 1'b0;
  endtask

  task automatic release_reg(input int p);
    @(negedge clk);
    rel_valid = 1'b1; rel_preg = p[PW-1:0];
    if (m_sh[p] > 0) m_sh[p]--; else fl.push_back(p);
    @(posedge clk);
    #1 rel_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1 flush = 1'b0;
    model_reset();
  endtask

  // Monitor: pops one prediction per renamed group.
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && out_vld) begin
      if (q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R7 unexpected output got out_vld=1 exp 0");
      end else begin
        e = q.pop_front();
        n_chk++;
        if (out_elim !== e.elim) begin
          n_fail++; $display("FAIL %s elim got %b exp %b", e.tag, out_elim, e.elim);
        end
        n_chk++;
        if (out_pd !== e.pd) begin
          n_fail++; $display("FAIL %s pd got %h exp %h", e.tag, out_pd, e.pd);
        end
        n_chk++;
        if (out_ps1 !== e.ps1 || out_off1 !== e.o1 || out_nz1 !== e.n1) begin
          n_fail++; $display("FAIL %s src1 got %h/%h/%b exp %h/%h/%b", e.tag,
                             out_ps1, out_off1, out_nz1, e.ps1, e.o1, e.n1);
        end
        n_chk++;
        if (out_ps2 !== e.ps2 || out_off2 !== e.o2 || out_nz2 !== e.n2) begin
          n_fail++; $display("FAIL %s src2 got %h/%h/%b exp %h/%h/%b", e.tag,
                             out_ps2, out_off2, out_nz2, e.ps2, e.o2, e.n2);
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    model_reset();
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld === 1'b0, "R11 out_vld after reset");
    chk(grp_ready === 1'b1, "R11 grp_ready after reset");

    // R1 R2 R3 R6 R8: copy chain with folded adds inside one group
    clr();
    slot(0, 0, 1, 2, 3, 0);
    slot(1, 1, 4, 1, 0, 0);
    slot(2, 2, 5, 4, 0, 100);
    slot(3, 2, 6, 5, 0, 1023);
    slot(4, 3, 7, 6, 6, 0);
    slot(5, 0, 8, 7, 5, 0);
    send("R1 R2 R3 R6 R8 chain");

    // R3 R4 R2: immediate out of range, running sum overflow, OR of distinct regs
    clr();
    slot(0, 2, 11, 2, 0, -1025);
    slot(1, 2, 12, 2, 0, -1024);
    slot(2, 2, 9, 6, 0, 1023);
    slot(3, 2, 9, 9, 0, 1023);
    slot(4, 2, 9, 9, 0, 1023);
    slot(5, 3, 13, 1, 2, 0);
    send("R3 R4 R2 limits");

    // R4 lower bound, slot without write, invalid slot
    clr();
    slot(0, 2, 15, 12, 0, -1024);
    slot(1, 2, 15, 15, 0, -1024);
    slot(2, 2, 15, 15, 0, -1024);
    slot(3, 2, 15, 15, 0, -1);
    slot(4, 0, 0, 15, 12, 0); s_wr[4] = 0;
    send("R4 R8 low bound");

    // R4 upper bound
    clr();
    for (int i = 0; i < 4; i++) slot(i, 2, 16, (i == 0) ? 9 : 16, 0, 1023);
    slot(4, 2, 16, 16, 0, 3);
    slot(5, 2, 16, 16, 0, 1);
    send("R4 high bound");

    // R5: every slot eliminated
    clr();
    for (int i = 0; i < W; i++) slot(i, (i % 2 == 0) ? 1 : 2, 20 + i, 16 - i, 0, i);
    send("R5 full width");

    // R9: flush then identity lookups
    do_flush();
    clr();
    slot(0, 0, 1, 5, 16, 0);
    slot(1, 0, 2, 15, 9, 0);
    send("R9 identity");

    // R7 R10: drain free list, stall, release shares
    do_flush();
    clr();
    slot(0, 1, 10, 3, 0, 0);
    for (int i = 1; i < W; i++) slot(i, 0, i, 2, 3, 0);
    send("R7 R10 share");
    for (int g = 0; g < 4; g++) begin
      clr();
      for (int i = 0; i < W; i++) slot(i, 0, i + 1, 4, 5, 0);
      send("R7 drain");
    end
    clr();
    for (int i = 0; i < 4; i++) slot(i, 0, i + 20, 1, 2, 0);
    send("R7 stall");
    release_reg(3);
    send("R10 stall after share release");
    release_reg(3);
    send("R10 R7 reuse released");

    // Random mix
    do_flush();
    for (int g = 0; g < 60; g++) begin
      if (g % 5 == 0) do_flush();
      clr();
      for (int i = 0; i < W; i++) begin
        if ($urandom_range(0, 7) != 0) begin
          slot(i, $urandom_range(0, 3), $urandom_range(0, 31), $urandom_range(0, 31),
               $urandom_range(0, 7), int'($urandom_range(0, 4095)) - 2048);
          if ($urandom_range(0, 7) == 0) s_wr[i] = 0;
        end
      end
      send("R6 R8 random");
    end

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R7 outstanding groups at end");
    summary();
  end
endmodule